// File: doc/BRIEF.md
# Debug trigger state sequencer

This block turns address and data comparator hits into a debug trigger. Three comparators each report a match line. Each comparator is set to one of two modes:

- **Forced mode:** a match counts at once.
- **Tagged mode:** a match only marks the fetched opcode. The match counts later, when the execution stage reports that the marked instruction has executed.

Once armed, the sequencer moves between two intermediate states. A per-state configuration word says, for each comparator, which state a counted match leads to. When the sequencer reaches the final state it can do either or both of the following, each under its own enable:

- pulse a trace-start line to the trace capture logic;
- pulse a breakpoint request to the CPU.

Software can also jump straight to the final state with a trigger write.

The sequencer stays in the final state until it is disarmed. A tag that is pending when the instruction queue is flushed is dropped, so an instruction that never executes never moves the sequencer.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the state output reads 00 (disarmed) and both pulse outputs are low.
- R2: An arm request moves state 00 to state 01 on the next clock. In any other state an arm request has no effect.
- R3: A disarm request returns the state to 00 on the next clock from any state. It overrides every other input in that cycle. It also drops all pending tags, so a later execute strobe for those tags causes no transition.
- R4: In state 01 or 10, a forced match k moves the state on the next clock to the 2-bit target held in bits [2k+1:2k] of the configuration word for the current state. State 01 uses `cfg_s1_i` and state 10 uses `cfg_s2_i`. A target of 00 means that match causes no transition.
- R5: A tagged-mode match never changes the state by itself. It leaves a pending tag for that comparator. A later cycle with the execute strobe high and that comparator's bit set in the executed tag vector counts as the match, with the targets of R4.
- R6: A flush request drops every pending tag. An execute strobe for a dropped tag causes no transition.
- R7: When several counted matches occur in the same cycle, the lowest-numbered one with a non-zero target decides the next state.
- R8: A software trigger in state 01 or 10 moves the state to 11 on the next clock. It takes priority over matches. In state 00 and state 11 it has no effect.
- R9: Each entry into state 11 gives a one-cycle trace-start pulse if tracing is enabled, and a one-cycle breakpoint pulse if breakpoints are enabled. Each pulse is high in the first cycle the state output reads 11.
- R10: State 11 is held until a disarm request. Matches in state 00 or state 11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm request (disarmed to state 01) |
| disarm_i | input | 1 | Return to disarmed, drop tags |
| trig_i | input | 1 | Software trigger write |
| trace_en_i | input | 1 | Enable trace-start pulse on final entry |
| brk_en_i | input | 1 | Enable breakpoint pulse on final entry |
| cfg_s1_i | input | 2*NUM_CMP | Per-comparator targets while in state 01 |
| cfg_s2_i | input | 2*NUM_CMP | Per-comparator targets while in state 10 |
| match_i | input | NUM_CMP | Comparator match lines |
| tag_mode_i | input | NUM_CMP | 1 = comparator in tagged mode, 0 = forced |
| exec_valid_i | input | 1 | An instruction reached execution this cycle |
| exec_tag_i | input | NUM_CMP | Tag hits carried by the executed instruction |
| flush_i | input | 1 | Instruction queue flush |
| state_o | output | 2 | Current state: 00 disarmed, 01, 10, 11 final |
| trace_start_o | output | 1 | One-cycle trace start pulse |
| brk_req_o | output | 1 | One-cycle breakpoint request |

## Verification
The hardest case to reach from the ports is a tag that is set, survives a state change or a flush, and is tested later by an execute strobe. The outcome depends on history that never appears on any output.

Directed sequences build this history:
- a tagged match, idle cycles, then an execute strobe;
- a tagged match, a flush, then a stale strobe;
- a tagged match, a disarm and re-arm, then a stale strobe.

A long random phase follows. It mixes tag modes, strobes and flushes, and a behavioural model checks the state and both pulses on every clock.

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int NUM_CMP = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm_i,
  input  logic                   disarm_i,
  input  logic                   trig_i,
  input  logic                   trace_en_i,
  input  logic                   brk_en_i,
  input  logic [2*NUM_CMP-1:0]   cfg_s1_i,
  input  logic [2*NUM_CMP-1:0]   cfg_s2_i,
  input  logic [NUM_CMP-1:0]     match_i,
  input  logic [NUM_CMP-1:0]     tag_mode_i,
  input  logic                   exec_valid_i,
  input  logic [NUM_CMP-1:0]     exec_tag_i,
  input  logic                   flush_i,
  output logic [1:0]             state_o,
  output logic                   trace_start_o,
  output logic                   brk_req_o
);
  localparam int CFG_W = 2*NUM_CMP;
  localparam logic [1:0] ST_IDLE = 2'b00, ST_ONE = 2'b01, ST_TWO = 2'b10, ST_FIN = 2'b11;

  logic [1:0]         state_q, state_d, tgt;
  logic [NUM_CMP-1:0] pend_q, pend_d, evt, exec_hit;
  logic               trace_q, brk_q;

  wire              armed    = (state_q == ST_ONE) || (state_q == ST_TWO);
  wire [CFG_W-1:0]  cfg      = (state_q == ST_TWO) ? cfg_s2_i : cfg_s1_i;
  wire              entering = (state_d == ST_FIN) && (state_q != ST_FIN);

  assign exec_hit = exec_valid_i ? exec_tag_i : '0;
  assign evt      = armed ? ((match_i & ~tag_mode_i) | (exec_hit & pend_q)) : '0;

  always_comb begin
    tgt = ST_IDLE;
    for (int k = NUM_CMP-1; k >= 0; k--)
      if (evt[k] && cfg[2*k +: 2] != ST_IDLE) tgt = cfg[2*k +: 2];
  end

  always_comb begin
    if (disarm_i)                     state_d = ST_IDLE;
    else if (armed && trig_i)         state_d = ST_FIN;
    else if (state_q == ST_IDLE && arm_i) state_d = ST_ONE;
    else if (tgt != ST_IDLE)          state_d = tgt;
    else                              state_d = state_q;
  end

  always_comb begin
    if (disarm_i || flush_i || !armed) pend_d = '0;
    else pend_d = (pend_q & ~exec_hit) | (match_i & tag_mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      trace_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      trace_q <= entering & trace_en_i;
      brk_q   <= entering & brk_en_i;
    end
  end

  assign state_o       = state_q;
  assign trace_start_o = trace_q;
  assign brk_req_o     = brk_q;

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && arm_i && !disarm_i) |=> state_o == ST_ONE);

  p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> state_o == ST_IDLE);

  p_tag_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !disarm_i && !trig_i && !exec_valid_i && ((match_i & ~tag_mode_i) == '0))
    |=> $stable(state_o));

  p_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_i && !disarm_i) |=> state_o == ST_FIN);

  p_brk_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |=> !brk_req_o);

  p_trace_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trace_start_o |=> !trace_start_o);

  p_pulse_in_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req_o || trace_start_o) |-> state_o == ST_FIN);

  p_final_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FIN && !disarm_i) |=> state_o == ST_FIN);
endmodule

// File: tb/dbg_trig_seq_test.sv
module dbg_trig_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic arm = 0, disarm = 0, trig = 0, trace_en = 1, brk_en = 1;
  logic [5:0] cfg1 = 6'b111110, cfg2 = 6'b110011;
  logic [2:0] match = 0, tag_mode = 0, exec_tag = 0;
  logic exec_valid = 0, flush = 0;
  logic [1:0] state;
  logic trace_start, brk_req;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_seq #(.NUM_CMP(3)) uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .disarm_i(disarm), .trig_i(trig),
    .trace_en_i(trace_en), .brk_en_i(brk_en), .cfg_s1_i(cfg1), .cfg_s2_i(cfg2),
    .match_i(match), .tag_mode_i(tag_mode), .exec_valid_i(exec_valid),
    .exec_tag_i(exec_tag), .flush_i(flush), .state_o(state),
    .trace_start_o(trace_start), .brk_req_o(brk_req));

  // behavioural reference
  int m_state;
  bit m_pend[3];
  bit m_tr, m_bk;
  always @(posedge clk) begin
    int ns, fld;
    bit np[3];
    bit live;
    if (!rst_n) begin
      m_state = 0; m_tr = 0; m_bk = 0;
      foreach (m_pend[i]) m_pend[i] = 0;
    end else begin
      live = (m_state == 1 || m_state == 2);
      ns = m_state;
      if (disarm) ns = 0;
      else if (live && trig) ns = 3;
      else if (m_state == 0 && arm) ns = 1;
      else if (live) begin
        for (int k = 0; k < 3; k++) begin
          fld = (m_state == 1) ? int'(cfg1[2*k +: 2]) : int'(cfg2[2*k +: 2]);
          if (((match[k] && !tag_mode[k]) || (exec_valid && exec_tag[k] && m_pend[k])) && fld != 0) begin
            ns = fld;
            break;
          end
        end
      end
      for (int k = 0; k < 3; k++) begin
        if (disarm || flush || !live) np[k] = 0;
        else np[k] = (m_pend[k] && !(exec_valid && exec_tag[k])) || (match[k] && tag_mode[k]);
      end
      m_tr = (ns == 3 && m_state != 3) && trace_en;
      m_bk = (ns == 3 && m_state != 3) && brk_en;
      m_state = ns;
      m_pend = np;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, int'(state), m_state, "model state");
    chk(cur_req, int'(trace_start), int'(m_tr), "model trace");
    chk(cur_req, int'(brk_req), int'(m_bk), "model brk");
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    arm = 0; disarm = 0; trig = 0; match = 0; exec_valid = 0; exec_tag = 0; flush = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(state), 0, "state in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(state), 0, "state after reset");
    chk("R1", int'(trace_start) + int'(brk_req), 0, "pulses after reset");

    cur_req = "R10"; match = 3'b001; cyc(); idle();
    chk("R10", int'(state), 0, "match ignored while disarmed");
    cur_req = "R2"; arm = 1; cyc(); idle();
    chk("R2", int'(state), 1, "arm");
    arm = 1; cyc(); idle();
    chk("R2", int'(state), 1, "arm ignored when armed");

    cur_req = "R4"; match = 3'b001; cyc(); idle();
    chk("R4", int'(state), 2, "forced match0 to state2");
    match = 3'b010; cyc(); idle();
    chk("R4", int'(state), 2, "zero target no move");
    cur_req = "R9"; match = 3'b100; cyc(); idle();
    chk("R9", int'(state), 3, "enter final");
    chk("R9", int'(trace_start), 1, "trace pulse");
    chk("R9", int'(brk_req), 1, "brk pulse");
    cyc();
    chk("R9", int'(trace_start) + int'(brk_req), 0, "pulses one cycle");
    cur_req = "R10"; match = 3'b111; cyc(); idle();
    chk("R10", int'(state), 3, "final holds");

    cur_req = "R3"; disarm = 1; cyc(); idle();
    chk("R3", int'(state), 0, "disarm from final");
    arm = 1; cyc(); idle();

    cur_req = "R5"; tag_mode = 3'b001; match = 3'b001; cyc(); idle();
    chk("R5", int'(state), 1, "tagged match alone no move");
    cyc(); cyc();
    exec_valid = 1; exec_tag = 3'b001; cyc(); idle();
    chk("R5", int'(state), 2, "tagged executes");

    cur_req = "R6"; tag_mode = 3'b100; match = 3'b100; cyc(); idle();
    flush = 1; cyc(); idle();
    exec_valid = 1; exec_tag = 3'b100; cyc(); idle();
    chk("R6", int'(state), 2, "flushed tag dropped");

    cur_req = "R7"; tag_mode = 0; disarm = 1; cyc(); idle(); arm = 1; cyc(); idle();
    match = 3'b011; cyc(); idle();
    chk("R7", int'(state), 2, "match0 beats match1");
    brk_en = 0;
    match = 3'b110; cyc(); idle();
    chk("R7", int'(state), 3, "skip zero-target match1");
    chk("R9", int'(brk_req), 0, "brk disabled");
    chk("R9", int'(trace_start), 1, "trace still on");
    brk_en = 1;

    cur_req = "R8"; disarm = 1; cyc(); idle();
    trig = 1; cyc(); idle();
    chk("R8", int'(state), 0, "trig ignored disarmed");
    arm = 1; cyc(); idle();
    trig = 1; match = 3'b001; cyc(); idle();
    chk("R8", int'(state), 3, "trig to final");
    chk("R8", int'(brk_req), 1, "trig brk");
    cyc();
    trig = 1; cyc(); idle();
    chk("R8", int'(brk_req), 0, "trig in final no pulse");

    cur_req = "R3"; disarm = 1; cyc(); idle(); arm = 1; cyc(); idle();
    tag_mode = 3'b001; match = 3'b001; cyc(); idle();
    disarm = 1; cyc(); idle(); arm = 1; cyc(); idle();
    exec_valid = 1; exec_tag = 3'b001; cyc(); idle();
    chk("R3", int'(state), 1, "disarm drops tags");
    disarm = 1; arm = 1; trig = 1; match = 3'b111; tag_mode = 0; cyc(); idle();
    chk("R3", int'(state), 0, "disarm wins");

    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      arm = ($urandom_range(0, 7) == 0);
      disarm = ($urandom_range(0, 40) == 0);
      trig = ($urandom_range(0, 30) == 0);
      match = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      tag_mode = 3'($urandom_range(0, 7));
      exec_valid = $urandom_range(0, 1) == 1;
      exec_tag = 3'($urandom_range(0, 7));
      flush = ($urandom_range(0, 9) == 0);
      trace_en = $urandom_range(0, 1) == 1;
      brk_en = $urandom_range(0, 1) == 1;
      if (i % 200 == 0) begin cfg1 = 6'($urandom()); cfg2 = 6'($urandom()); end
      cyc();
    end
    idle();
    finish_run();
  end
endmodule